// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management side of a two-wire management bus: a clock pin that it always drives, and a bidirectional data pin that it controls through an output value and an output-enable. A host issues one request at a time. Each request holds a read/write flag, a 5-bit PHY address, a 5-bit register address and 16-bit write data. The block turns the request into a complete management frame to read or write one 16-bit register in an external PHY. A read returns its data on `rdata` together with a one-cycle `done` pulse.

Frame timing is built from phases. Each phase lasts a fixed number of system clocks, derived at elaboration from the system clock rate and the highest allowed management clock rate. Each driven bit takes three phases: clock low with the data set up, clock high, clock low again with the data unchanged. The read turnaround is one released clock pulse. Each received bit takes two phases: clock high, when the bit is sampled, then clock low. A write ends with one phase in which the data line is released and the clock is low.

Top module: `mgmt_frame_master`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mdc`, `md_oe`, `busy` and `done` are all low.
- R2: A frame begins with 32 driven ones, then the start bits 0,1, then a 2-bit opcode: 1,0 for a read and 0,1 for a write.
- R3: After the opcode come the PHY address and then the register address, 5 bits each, most significant bit first.
- R4: Each driven bit produces exactly one rising edge of `mdc`. `md_out` changes only while `mdc` is low, and it holds its value for the whole time `mdc` is high.
- R5: A read drives 46 bits. It then deasserts `md_oe` and gives one turnaround clock pulse. It then gives 16 more pulses with `md_oe` low, sampling `md_in` while `mdc` is high. The sampled bits, MSB first, appear on `rdata` when `done` pulses.
- R6: A write drives the turnaround bits 1,0 after the register address, then the 16 bits of write data MSB first, for 64 driven bits in total.
- R7: After the last data bit of a write, `md_oe` is low and `mdc` stays low for at least one full phase before `done`. A write produces no rising edge of `mdc` while `md_oe` is low.
- R8: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the frame ends. `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R9: A request presented while `busy` is high is ignored: the frame in progress and its result are unchanged.
- R10: A phase lasts PH = ceil(CLK_HZ / (2·MDC_MAX_HZ)) system clocks, which is 5 with the defaults. Every high pulse of `mdc` lasts exactly PH cycles, and rising edges are never closer than 2·PH cycles.
- R11: A request presented in the cycle in which `done` is high is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write register, 0 = read register |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rdata | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management bus clock |
| md_out | output | 1 | Data value to drive on the bus |
| md_oe | output | 1 | Output enable for the data pin |
| md_in | input | 1 | Data value seen on the bus pin |

## Verification
Two events can fall in the same cycle. One is the completion of a frame: `done` high and the state returning to idle. The other is the acceptance of a new request. The bench provokes this by presenting a second request in exactly the cycle in which it observes `done`. It judges the result by checking three things: `busy` is high one cycle later, the second frame decodes bit for bit at the bus, and the result of the first frame was already correct. The bench also holds conflicting requests on the inputs for several cycles in the middle of random frames. It then confirms that the decoded frame and the returned read data still match the original request.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int PRE_BITS  = 32;
    localparam int ADDR_BITS = 5;
    localparam int DATA_BITS = 16;
    localparam int HDR_BITS  = PRE_BITS + 2 + 2 + ADDR_BITS + ADDR_BITS;
    localparam int WR_BITS   = HDR_BITS + 2 + DATA_BITS;

    localparam logic [1:0] SYNC_PAT  = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] TURN_PAT  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_TURN,
        ST_RECV,
        ST_RELEASE
    } mg_state_e;

    typedef struct packed {
        logic                 write;
        logic [ADDR_BITS-1:0] phy;
        logic [ADDR_BITS-1:0] regad;
        logic [DATA_BITS-1:0] wdata;
    } mg_req_t;

    // Whole outgoing bit stream, first bit at the MSB.
    function automatic logic [WR_BITS-1:0] build_frame(input mg_req_t r);
        logic [1:0] opc;
        opc = r.write ? OPC_WRITE : OPC_READ;
        return {{PRE_BITS{1'b1}}, SYNC_PAT, opc, r.phy, r.regad, TURN_PAT, r.wdata};
    endfunction

    // Shortest bus clock period is two phases (receive bits).
    function automatic int phase_cycles(input longint clk_hz, input longint max_hz);
        longint q;
        q = (clk_hz + 2 * max_hz - 1) / (2 * max_hz);
        return (q < 1) ? 1 : int'(q);
    endfunction

endpackage

// File: rtl/mgmt_tick.sv
module mgmt_tick #(
    parameter int PH = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (PH > 1) ? $clog2(PH) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(PH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: phase counter never passes the phase length
    a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < PH);

endmodule

// File: rtl/mgmt_rx_shift.sv
module mgmt_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else if (en) begin
            sh_q <= {sh_q[W-2:0], din};
        end
    end

    assign q = sh_q;

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 250_000_000,
    parameter int unsigned MDC_MAX_HZ = 25_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_phy,
    input  logic [ADDR_BITS-1:0] req_reg,
    input  logic [DATA_BITS-1:0] req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 mdc,
    output logic                 md_out,
    output logic                 md_oe,
    input  logic                 md_in
);
    localparam int PH  = phase_cycles(longint'(CLK_HZ), longint'(MDC_MAX_HZ));
    localparam int BCW = $clog2(WR_BITS + 1);

    mg_state_e          state_q;
    logic [1:0]         phase_q;
    logic [BCW-1:0]     bits_q;
    logic [WR_BITS-1:0] frame_q;
    logic               wr_q;
    logic               done_q;
    logic               tick;
    logic               cap_en;
    logic [BCW-1:0]     last_bit;
    mg_req_t            req_s;

    assign req_s = '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
    assign last_bit = wr_q ? BCW'(WR_BITS - 1) : BCW'(HDR_BITS - 1);

    mgmt_tick #(.PH(PH)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    assign cap_en = tick && (state_q == ST_RECV) && (phase_q == 2'd0);

    mgmt_rx_shift #(.W(DATA_BITS)) u_rx (
        .clk (clk),
        .rst (rst),
        .en  (cap_en),
        .din (md_in),
        .q   (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            bits_q  <= '0;
            frame_q <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        frame_q <= build_frame(req_s);
                        wr_q    <= req_write;
                        state_q <= ST_DRIVE;
                        phase_q <= '0;
                        bits_q  <= '0;
                    end
                end
                ST_DRIVE: begin
                    if (tick) begin
                        if (phase_q == 2'd2) begin
                            phase_q <= '0;
                            frame_q <= {frame_q[WR_BITS-2:0], 1'b0};
                            bits_q  <= bits_q + 1'b1;
                            if (bits_q == last_bit) begin
                                state_q <= wr_q ? ST_RELEASE : ST_TURN;
                            end
                        end else begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end
                end
                ST_TURN: begin
                    if (tick) begin
                        if (phase_q == 2'd2) begin
                            phase_q <= '0;
                            bits_q  <= '0;
                            state_q <= ST_RECV;
                        end else begin
                            phase_q <= phase_q + 1'b1;
                        end
                    end
                end
                ST_RECV: begin
                    if (tick) begin
                        if (phase_q == 2'd0) begin
                            phase_q <= 2'd1;
                        end else begin
                            phase_q <= '0;
                            bits_q  <= bits_q + 1'b1;
                            if (bits_q == BCW'(DATA_BITS - 1)) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end
                        end
                    end
                end
                ST_RELEASE: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mdc    = (((state_q == ST_DRIVE) || (state_q == ST_TURN)) && (phase_q == 2'd1))
                 || ((state_q == ST_RECV) && (phase_q == 2'd0));
    assign md_oe  = (state_q == ST_DRIVE);
    assign md_out = md_oe & frame_q[WR_BITS-1];
    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;

    // R1: bus quiet whenever no frame runs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !md_oe));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: busy already low when done shows
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: the captured operation holds for the whole frame
    a_r9_hold_op: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(wr_q)));

    // R4: driven data holds while the clock is high
    a_r4_hold_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && md_oe) |=> (!mdc || $stable(md_out)));

    // R5: data pin released during turnaround and receive
    a_r5_released: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_q && $fell(md_oe)) |=> !md_oe);

endmodule

// File: tb/mgmt_frame_master_tb.sv
`timescale 1ns/1ps
module mgmt_frame_master_tb;

    localparam int PH_EXP = (250_000_000 + 2 * 25_000_000 - 1) / (2 * 25_000_000);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, md_out, md_oe;
    logic [15:0] rdata;
    logic        md_in = 1'b1;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mgmt_frame_master u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .mdc(mdc), .md_out(md_out),
        .md_oe(md_oe), .md_in(md_in)
    );

    // Bus-side monitor and PHY model
    logic [63:0] cap;
    int          ncap, nrel, hi_cnt, rel_low, err_hi, err_iv, err_stab;
    logic        prev_mdc = 1'b0;
    logic        rise_val;
    logic [15:0] phy_data;
    longint      cyc = 0, last_rise = 0;
    bit          have_rise = 1'b0;

    initial begin
        cap = '0; ncap = 0; nrel = 0; hi_cnt = 0; rel_low = 0;
        err_hi = 0; err_iv = 0; err_stab = 0; phy_data = '0; rise_val = 1'b0;
    end

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (mdc && !prev_mdc) begin
                if (have_rise && (cyc - last_rise) < 2 * PH_EXP) err_iv++;
                have_rise = 1'b1;
                last_rise = cyc;
                hi_cnt = 0;
                if (md_oe) begin
                    cap = {cap[62:0], md_out};
                    ncap++;
                    rise_val = md_out;
                end else begin
                    nrel++;
                    if (nrel >= 2 && nrel <= 17) md_in = phy_data[17 - nrel];
                end
            end
            if (mdc) begin
                hi_cnt++;
                if (md_oe && md_out !== rise_val) err_stab++;
            end
            if (!mdc && prev_mdc && hi_cnt != PH_EXP) err_hi++;
            if (!md_oe && !mdc) rel_low++;
            else rel_low = 0;
        end
        prev_mdc = mdc;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] pd, input string tag);
        cap = '0; ncap = 0; nrel = 0; phy_data = pd; md_in = 1'b1;
        req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, tag, "busy after accept", longint'(busy), 1);
        chk(done === 1'b0, "R8", "done one cycle only", longint'(done), 0);
    endtask

    task automatic finish(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] wd, input logic [15:0] pd, input bit inject);
        int n = 0;
        int bad_busy = 0;
        int inj_at = inject ? int'(1 + ($urandom % 300)) : -10;
        logic [45:0] hdr;
        string tg = inject ? "R9" : "R3";
        while (done !== 1'b1 && n < 4000) begin
            if (busy !== 1'b1) bad_busy++;
            if (n == inj_at) begin
                req_valid = 1'b1; req_write = ~wr; req_phy = ~phy;
                req_reg = ~rg; req_wdata = ~wd;
            end
            if (n == inj_at + 3) req_valid = 1'b0;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n < 4000, "R8", "frame ends with done", n, 0);
        chk(bad_busy == 0, "R8", "busy held during frame", bad_busy, 0);
        chk(busy === 1'b0, "R8", "busy low at done", longint'(busy), 0);
        hdr = wr ? cap[63:18] : cap[45:0];
        chk(hdr[45:10] == {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10)}, "R2",
            "preamble/start/opcode", longint'(hdr[45:10]),
            longint'({32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10)}));
        chk(hdr[9:0] == {phy, rg}, tg, "phy and register address",
            longint'(hdr[9:0]), longint'({phy, rg}));
        if (wr) begin
            chk(ncap == 64, "R6", "driven bit count", ncap, 64);
            chk(cap[17:0] == {2'b10, wd}, inject ? "R9" : "R6", "turnaround and data",
                longint'(cap[17:0]), longint'({2'b10, wd}));
            chk(nrel == 0, "R7", "no released clock on write", nrel, 0);
            chk(rel_low >= PH_EXP, "R7", "release phase before done", rel_low, PH_EXP);
        end else begin
            chk(ncap == 46, "R5", "driven bit count", ncap, 46);
            chk(nrel == 17, "R5", "released clock pulses", nrel, 17);
            chk(rdata == pd, inject ? "R9" : "R5", "read data", longint'(rdata), longint'(pd));
        end
    endtask

    task automatic run(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [15:0] pd, input bit inject);
        @(negedge clk);
        issue(wr, phy, rg, wd, pd, "R8");
        finish(wr, phy, rg, wd, pd, inject);
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'd913));
        repeat (3) @(negedge clk);
        chk(mdc === 1'b0 && md_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R1", "outputs during reset", longint'({mdc, md_oe, busy, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(mdc === 1'b0 && md_oe === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R1", "outputs after reset", longint'({mdc, md_oe, busy, done}), 0);

        // Directed corners
        run(1'b0, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 1'b0);
        run(1'b1, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0);
        run(1'b0, 5'd31, 5'd1,  16'h0000, 16'h0000, 1'b0);
        run(1'b1, 5'd0,  5'd0,  16'h0000, 16'h0000, 1'b0);
        run(1'b0, 5'h15, 5'h0A, 16'h0000, 16'hA55A, 1'b1);

        // R11: new request in the done cycle
        @(negedge clk);
        issue(1'b1, 5'h03, 5'h11, 16'h8001, 16'h0000, "R8");
        finish(1'b1, 5'h03, 5'h11, 16'h8001, 16'h0000, 1'b0);
        issue(1'b0, 5'h1C, 5'h04, 16'h0000, 16'h7E81, "R11");
        finish(1'b0, 5'h1C, 5'h04, 16'h0000, 16'h7E81, 1'b0);
        issue(1'b0, 5'h02, 5'h1F, 16'h0000, 16'h1234, "R11");
        finish(1'b0, 5'h02, 5'h1F, 16'h0000, 16'h1234, 1'b0);

        // Constrained random
        for (int i = 0; i < 20; i++) begin
            bit          w   = 1'($urandom);
            logic [4:0]  p   = 5'($urandom);
            logic [4:0]  r   = 5'($urandom);
            logic [15:0] d   = 16'($urandom);
            logic [15:0] pd  = 16'($urandom);
            bit          inj = ($urandom % 3) == 0;
            run(w, p, r, d, pd, inj);
        end

        chk(err_hi == 0, "R10", "mdc high pulse width", err_hi, 0);
        chk(err_iv == 0, "R10", "mdc rising spacing", err_iv, 0);
        chk(err_stab == 0, "R4", "data stable while mdc high", err_stab, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule